// File: doc/BRIEF.md
# Edge-Counting Timer with Match Outputs

This block is a 32-bit timer/counter core for a peripheral subsystem. It has two modes. In timer mode the count register advances on every clock. In counter mode it advances only when a chosen edge type appears on one of several asynchronous capture pins. Each pin is first brought into the clock domain through two flops. The block then compares two consecutive synchronized samples and classifies the change as a rise, a fall or no change.

Four match channels each compare a stored value with the count. On any clock where the two are equal, the channel applies its programmed action to its own match output bit: clear, set, toggle or nothing. Software reaches the block through a single-cycle write port and a combinational read port, indexed by word.

Word map: 0 holds the count value, 1 holds the mode/select control, 2 holds the match action/output register, and 3 to 6 hold the match values for channels 0 to 3.

Top module: `edge_match_timer`

## Requirements
- R1: While reset is asserted, every readable register reads 0 and all match outputs are 0.
- R2: When control bits 1:0 are 00 (timer mode), the count rises by exactly 1 on every clock.
- R3: Control bits 1:0 set to 01 count rising edges of the selected pin. A pin change applied before clock edge k shows in the count after clock edge k+2.
- R4: Control bits 1:0 set to 10 count falling edges of the selected pin, one count per falling edge.
- R5: Control bits 1:0 set to 11 count every level change of the selected pin. With no change, the count holds.
- R6: Control bits 3:2 select the capture pin. Activity on the unselected pins has no effect on the count.
- R7: Each channel i has a 2-bit action field at bits 2i+5:2i+4 of word 2. The codes are 00 no action, 01 drive the output to 0, 10 drive it to 1, and 11 invert it. The action is applied at the clock edge that ends a cycle in which the count equals match value i.
- R8: Bits 3:0 of word 2 are the match output bits, readable and writable. Bits 31:12 of word 2 always read 0.
- R9: A write to word 0 loads the count and takes priority over counting. The count wraps from 0xFFFFFFFF to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Word index for the write |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 3 | Word index for the read |
| rd_data_o | output | 32 | Combinational read data |
| cap_i | input | 4 | Asynchronous capture pins |
| match_o | output | 4 | Match output bits |

## Verification
The assertions assume that a write to word 2 takes precedence over a match action in the same cycle. They also assume that a change of pin selection or mode is made only while the capture pins are quiet, so the previous sample belongs to the same pin. The stimulus writes control only when all pins have been low for several clocks. It holds every capture level for four clocks, which is longer than the synchronizer latency. In the match tests, the count is frozen in counter mode while the channel is set up, then released in timer mode, so each match value is equal to the count for exactly one clock.

// File: rtl/emt_pkg.sv
package emt_pkg;
  typedef enum logic [1:0] {
    CM_TIMER = 2'b00,
    CM_RISE  = 2'b01,
    CM_FALL  = 2'b10,
    CM_BOTH  = 2'b11
  } cnt_mode_e;

  typedef enum logic [1:0] {
    MA_NONE = 2'b00,
    MA_CLR  = 2'b01,
    MA_SET  = 2'b10,
    MA_TGL  = 2'b11
  } match_act_e;

  localparam int unsigned ADR_COUNT = 0;
  localparam int unsigned ADR_CTRL  = 1;
  localparam int unsigned ADR_MACT  = 2;
  localparam int unsigned ADR_MVAL0 = 3;
  localparam int unsigned ACT_LSB   = 4;
endpackage

// File: rtl/emt_cap_edge.sv
module emt_cap_edge
  import emt_pkg::*;
#(
  parameter int unsigned N_CAP = 4,
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CAP-1:0] cap_i,
  input  logic [SEL_W-1:0] sel_i,
  input  cnt_mode_e        mode_i,
  output logic             step_o
);
  logic [N_CAP-1:0] meta_q, sync_q;
  logic             prev_q, cur;
  logic             rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= cap_i;
      sync_q <= meta_q;
      prev_q <= cur;
    end
  end

  assign cur  = sync_q[sel_i];
  assign rise = cur & ~prev_q;
  assign fall = ~cur & prev_q;

  always_comb begin
    unique case (mode_i)
      CM_TIMER: step_o = 1'b1;
      CM_RISE:  step_o = rise;
      CM_FALL:  step_o = fall;
      CM_BOTH:  step_o = rise | fall;
      default:  step_o = 1'b0;
    endcase
  end

  // R5
  no_change_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != CM_TIMER && $stable(sync_q) && $past(mode_i) == mode_i
     && $past(sel_i) == sel_i && $past(cur) == cur && prev_q == cur) |-> !step_o);
endmodule

// File: rtl/emt_counter.sv
module emt_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (ld_i)   cnt_o <= ld_val_i;
    else if (step_i) cnt_o <= cnt_o + 1'b1;
  end

  // R2
  step_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && step_i) |=> cnt_o == $past(cnt_o) + 1'b1);
  // R5
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && !step_i) |=> $stable(cnt_o));
  // R9
  load_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> cnt_o == $past(ld_val_i));
endmodule

// File: rtl/emt_match_chan.sv
module emt_match_chan
  import emt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  match_act_e       act_i,
  input  logic             wr_i,
  input  logic             wval_i,
  output logic             bit_o
);
  logic hit;
  assign hit = (cnt_i == cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bit_o <= 1'b0;
    else if (wr_i) bit_o <= wval_i;
    else if (hit) begin
      unique case (act_i)
        MA_CLR:  bit_o <= 1'b0;
        MA_SET:  bit_o <= 1'b1;
        MA_TGL:  bit_o <= ~bit_o;
        default: bit_o <= bit_o;
      endcase
    end
  end

  // R7
  act_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !wr_i && act_i == MA_SET) |=> bit_o);
  // R7
  act_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !wr_i && act_i == MA_CLR) |=> !bit_o);
  // R7
  act_tgl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !wr_i && act_i == MA_TGL) |=> bit_o != $past(bit_o));
  // R7
  no_hit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!hit || act_i == MA_NONE) && !wr_i) |=> $stable(bit_o));
  // R8
  sw_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> bit_o == $past(wval_i));
endmodule

// File: rtl/edge_match_timer.sv
module edge_match_timer
  import emt_pkg::*;
#(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned N_CAP   = 4,
  parameter int unsigned N_MATCH = 4,
  parameter int unsigned ADDR_W  = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [CNT_W-1:0]   wr_data_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [CNT_W-1:0]   rd_data_o,
  input  logic [N_CAP-1:0]   cap_i,
  output logic [N_MATCH-1:0] match_o
);
  localparam int unsigned SEL_W   = (N_CAP > 1) ? $clog2(N_CAP) : 1;
  localparam int unsigned ACT_MSB = ACT_LSB + 2 * N_MATCH - 1;

  cnt_mode_e              mode_q;
  logic [SEL_W-1:0]       sel_q;
  match_act_e             act_q [N_MATCH];
  logic [CNT_W-1:0]       cmp_q [N_MATCH];
  logic [CNT_W-1:0]       cnt;
  logic                   step;
  logic                   wr_cnt, wr_ctrl, wr_mact;

  assign wr_cnt  = wr_en_i && (wr_addr_i == ADDR_W'(ADR_COUNT));
  assign wr_ctrl = wr_en_i && (wr_addr_i == ADDR_W'(ADR_CTRL));
  assign wr_mact = wr_en_i && (wr_addr_i == ADDR_W'(ADR_MACT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= CM_TIMER;
      sel_q  <= '0;
    end else if (wr_ctrl) begin
      mode_q <= cnt_mode_e'(wr_data_i[1:0]);
      sel_q  <= wr_data_i[2 +: SEL_W];
    end
  end

  emt_cap_edge #(.N_CAP(N_CAP), .SEL_W(SEL_W)) i_cap_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (cap_i),
    .sel_i  (sel_q),
    .mode_i (mode_q),
    .step_o (step)
  );

  emt_counter #(.CNT_W(CNT_W)) i_counter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_i     (wr_cnt),
    .ld_val_i (wr_data_i),
    .step_i   (step),
    .cnt_o    (cnt)
  );

  for (genvar g = 0; g < N_MATCH; g++) begin : g_chan
    logic wr_val;
    assign wr_val = wr_en_i && (wr_addr_i == ADDR_W'(ADR_MVAL0 + g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        act_q[g] <= MA_NONE;
        cmp_q[g] <= '0;
      end else begin
        if (wr_mact) act_q[g] <= match_act_e'(wr_data_i[ACT_LSB + 2*g +: 2]);
        if (wr_val)  cmp_q[g] <= wr_data_i;
      end
    end

    emt_match_chan #(.CNT_W(CNT_W)) i_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cnt_i  (cnt),
      .cmp_i  (cmp_q[g]),
      .act_i  (act_q[g]),
      .wr_i   (wr_mact),
      .wval_i (wr_data_i[g]),
      .bit_o  (match_o[g])
    );
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == ADDR_W'(ADR_COUNT)) begin
      rd_data_o = cnt;
    end else if (rd_addr_i == ADDR_W'(ADR_CTRL)) begin
      rd_data_o[1:0]       = mode_q;
      rd_data_o[2 +: SEL_W] = sel_q;
    end else if (rd_addr_i == ADDR_W'(ADR_MACT)) begin
      rd_data_o[N_MATCH-1:0] = match_o;
      for (int i = 0; i < N_MATCH; i++) rd_data_o[ACT_LSB + 2*i +: 2] = act_q[i];
    end else begin
      for (int i = 0; i < N_MATCH; i++)
        if (rd_addr_i == ADDR_W'(ADR_MVAL0 + i)) rd_data_o = cmp_q[i];
    end
  end

  // R8
  mact_reserved_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i == ADDR_W'(ADR_MACT)) |-> rd_data_o[CNT_W-1:ACT_MSB+1] == '0);
endmodule

// File: tb/test_edge_match_timer.sv
module test_edge_match_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [2:0]  rd_addr_i = '0;
  logic [31:0] rd_data_o;
  logic [3:0]  cap_i = '0;
  logic [3:0]  match_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  edge_match_timer i_edge_match_timer (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .rd_addr_i, .rd_data_o, .cap_i, .match_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input int adr, input logic [31:0] d);
    wr_en_i = 1'b1; wr_addr_i = 3'(adr); wr_data_i = d;
    @(posedge clk_i); @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input int adr, output logic [31:0] d);
    rd_addr_i = 3'(adr); #1; d = rd_data_o;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got 0x%08h expected 0x%08h", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    // R1 reset values, sampled while reset is held
    wait_n(2);
    for (int a = 0; a < 7; a++) begin
      rd(a, v); chk("R1", v, 0);
    end
    chk("R1", {28'd0, match_o}, 0);
    rst_ni = 1'b1;
    wait_n(1);

    // R2 timer mode
    for (int n = 1; n <= 6; n++) begin
      wr(0, 32'h100 * n);
      rd(0, v); chk("R9", v, 32'h100 * n);
      wait_n(n);
      rd(0, v); chk("R2", v, 32'h100 * n + n);
    end
    // R9 wrap
    wr(0, 32'hFFFF_FFFE);
    wait_n(3);
    rd(0, v); chk("R9", v, 32'h1);

    // R3 latency
    wr(1, {28'd0, 2'd1, 2'b01});
    wr(0, 0);
    cap_i[1] = 1'b1;
    wait_n(2); rd(0, v); chk("R3", v, 0);
    wait_n(1); rd(0, v); chk("R3", v, 1);
    cap_i = '0; wait_n(4);

    // R3 R4 R5 R6 sweep over pins and edge modes
    for (int sel = 0; sel < 4; sel++) begin
      for (int m = 1; m < 4; m++) begin
        wr(1, 32'((sel << 2) | m));
        wr(0, 0);
        for (int p = 0; p < 3; p++) begin
          for (int h = 0; h < 8; h++) begin
            logic [3:0] c;
            c = ~cap_i;
            c[sel] = (h < 4);
            cap_i = c;
            wait_n(1);
          end
        end
        cap_i = '0;
        wait_n(5);
        rd(0, v);
        case (m)
          1: chk("R3", v, 3);
          2: chk("R4", v, 3);
          default: chk("R5", v, 6);
        endcase
        // R6 toggling only unselected pins
        wr(0, 0);
        for (int h = 0; h < 10; h++) begin
          logic [3:0] c;
          c = ~cap_i; c[sel] = 1'b0; cap_i = c;
          wait_n(1);
        end
        cap_i = '0;
        wait_n(5);
        rd(0, v); chk("R6", v, 0);
      end
    end

    // R7 match actions, every channel, code and starting level
    for (int ch = 0; ch < 4; ch++) begin
      for (int a = 0; a < 4; a++) begin
        for (int b = 0; b < 2; b++) begin
          logic exp_bit;
          wr(1, 32'b0001);            // rising edges on quiet pin 0: frozen
          wr(0, 100);
          for (int k = 0; k < 4; k++) wr(3 + k, (k == ch) ? 103 : 32'h8000_0000);
          wr(2, 32'((a << (4 + 2*ch)) | (b << ch)));
          wr(1, 32'b0000);            // run
          wait_n(8);
          exp_bit = (a == 0) ? b[0] : (a == 1) ? 1'b0 : (a == 2) ? 1'b1 : ~b[0];
          chk("R7", {31'd0, match_o[ch]}, {31'd0, exp_bit});
          rd(2, v);
          chk("R8", {31'd0, v[ch]}, {31'd0, exp_bit});
          chk("R7", {30'd0, v[4+2*ch +: 2]}, 32'(a));
        end
      end
    end

    // R8 reserved bits and write of output bits
    wr(1, 32'b0001);
    wr(2, 32'hFFFF_FFFF);
    rd(2, v);
    chk("R8", v, 32'h0000_0FFF);
    chk("R8", {28'd0, match_o}, 32'hF);
    wr(2, 32'h0000_0005);
    rd(2, v);
    chk("R8", v, 32'h5);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule